// File: doc/BRIEF.md
# Three-Wire Serial PROM Host Engine

This block drives a three-wire serial EEPROM on behalf of on-chip logic. A client hands it one command at a time over a valid/ready request port: read a word, write a word, erase a word, unlock or lock programming, erase the whole array, or fill the whole array with one word. The engine turns the command into a serial frame on chip-select, serial clock and data-out-to-device. It collects read data from the device's data line and reports the outcome on a one-cycle response strobe.

Programming commands take the device into a self-timed cycle. The engine ends the frame and holds chip-select low for the minimum spacing. It then raises chip-select with the serial clock parked low and watches the device's data line until it goes high. Only then does it answer. If the line stays low past a cycle limit, the response carries an error flag. An optional protect mode appends a lock frame after every programming command. Word width, serial clock rate, spacing and poll limit are all parameters.

Top module: `uwire_prom_host`

## Requirements
- R1: After reset, prom_cs and prom_sk are low, req_ready is high and rsp_valid is low.
- R2: Chip-select rises only while prom_sk is low, and the first bit clocked in after chip-select rises is a 1 (start bit).
- R3: A frame is sent MSB first as start bit, 2-bit opcode, ADDR_W address bits (6 for 16-bit words, 7 for 8-bit words), then data for writes. Opcodes: read 10, write 01, erase 11, extended 00. For extended frames the top two address bits select the action (11 unlock, 00 lock, 10 erase-all, 01 write-all) and the rest are zero. Request codes on req_op: 0 read, 1 write, 2 erase, 3 unlock, 4 lock, 5 erase-all, 6 write-all, 7 treated as lock. Read, write and write-all frames have 3+ADDR_W+WORD_W clock pulses; the others have 3+ADDR_W.
- R4: prom_di changes only while prom_sk is low; each clock phase lasts SK_HALF system cycles.
- R5: On a read, the line is sampled at every falling edge of prom_sk. The dummy zero that follows the address is discarded. The last WORD_W samples are returned MSB first on rsp_data.
- R6: Between any two chip-select high intervals, including those of a ready poll, chip-select stays low for at least GAP_CYC = ceil(CS_GAP_NS / CLK_PERIOD_NS) cycles.
- R7: After a write, erase, erase-all or write-all frame, the engine drops chip-select and waits the spacing. It then raises chip-select with the clock held low and answers only after prom_do reads high.
- R8: If prom_do stays low for POLL_LIMIT cycles of polling, the response carries rsp_err = 1; every other response has rsp_err = 0.
- R9: With AUTO_LOCK = 1, every programming command is followed by a lock frame before the response, so a later write without a new unlock leaves the array unchanged.
- R10: One request is served at a time: req_ready is low from acceptance until the response, and rsp_valid is a single-cycle pulse.
- R11: prom_sk toggles only while prom_cs is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Engine idle and accepting |
| req_op | input | 3 | Command code (see R3) |
| req_addr | input | ADDR_W | Word address |
| req_data | input | WORD_W | Write / write-all data |
| rsp_valid | output | 1 | One-cycle completion strobe |
| rsp_data | output | WORD_W | Read data |
| rsp_err | output | 1 | Ready poll timed out |
| prom_cs | output | 1 | Device chip-select |
| prom_sk | output | 1 | Device serial clock |
| prom_di | output | 1 | Serial data toward the device |
| prom_do | input | 1 | Serial data / ready status from the device |

## Verification
The assertions assume that prom_do is synchronous to clk, as a registered device model drives it. They also assume that SK_HALF is at least 2, so that a response to a rising serial clock edge settles before the falling edge samples it. The bench's device model updates its data line half a system cycle after it sees each rising clock edge. It drives the ready level only while no frame is in progress, which keeps both assumptions true. Requests are offered only while req_ready is high, so the single-outstanding rule holds by construction of the stimulus.

// File: rtl/uw_pkg.sv
// Shared types for the three-wire PROM host engine.
// Assumes: command codes as listed in the brief (R3).
package uw_pkg;

    typedef enum logic [2:0] {
        OP_READ      = 3'd0,
        OP_WRITE     = 3'd1,
        OP_ERASE     = 3'd2,
        OP_UNLOCK    = 3'd3,
        OP_LOCK      = 3'd4,
        OP_ERASE_ALL = 3'd5,
        OP_WRITE_ALL = 3'd6,
        OP_RSVD      = 3'd7
    } uw_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SHIFT_LO,
        ST_SHIFT_HI,
        ST_GAP,
        ST_POLL
    } uw_state_e;

    // True for commands that start a self-timed programming cycle.
    function automatic logic uw_is_prog(uw_op_e op);
        return (op == OP_WRITE) || (op == OP_ERASE) ||
               (op == OP_ERASE_ALL) || (op == OP_WRITE_ALL);
    endfunction

endpackage

// File: rtl/uw_count.sv
// Wrapping cycle counter: counts while en is high and flags the
// last cycle of each LIMIT-cycle window. clr restarts it at zero.
// Assumes: LIMIT >= 1.
module uw_count #(
    parameter int LIMIT = 4,
    localparam int CW   = (LIMIT < 2) ? 1 : $clog2(LIMIT)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    output logic done
);
    logic [CW-1:0] cnt_q;
    logic          at_end;

    assign at_end = (cnt_q == CW'(LIMIT - 1));
    assign done   = en && at_end;

    // Advance the window position, wrapping at LIMIT.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q <= '0;
        end else if (en) begin
            cnt_q <= at_end ? '0 : cnt_q + 1'b1;
        end
    end

    a_r4_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(LIMIT - 1));

endmodule

// File: rtl/uw_frame.sv
// Builds the serial frame for one command, left aligned, and the
// number of clock pulses it needs (R3). Purely combinational.
// Assumes: ADDR_W >= 2 so the extended action fits in the address.
module uw_frame import uw_pkg::*; #(
    parameter int WORD_W = 16,
    parameter int ADDR_W = 6,
    localparam int FW    = 3 + ADDR_W + WORD_W,
    localparam int CW    = $clog2(FW + 1)
) (
    input  uw_op_e            op,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] data,
    output logic [FW-1:0]     frame,
    output logic [CW-1:0]     nbits
);
    localparam logic [WORD_W-1:0]   NO_DATA = '0;
    localparam logic [ADDR_W-3:0]   EXT_PAD = '0;

    // Select opcode, address field and payload for the command.
    always_comb begin
        nbits = CW'(3 + ADDR_W);
        unique case (op)
            OP_READ:      begin frame = {3'b110, addr, NO_DATA}; nbits = CW'(FW); end
            OP_WRITE:     begin frame = {3'b101, addr, data};    nbits = CW'(FW); end
            OP_ERASE:           frame = {3'b111, addr, NO_DATA};
            OP_UNLOCK:          frame = {3'b100, 2'b11, EXT_PAD, NO_DATA};
            OP_ERASE_ALL:       frame = {3'b100, 2'b10, EXT_PAD, NO_DATA};
            OP_WRITE_ALL: begin frame = {3'b100, 2'b01, EXT_PAD, data}; nbits = CW'(FW); end
            default:            frame = {3'b100, 2'b00, EXT_PAD, NO_DATA};
        endcase
    end

endmodule

// File: rtl/uwire_prom_host.sv
// Host engine for a three-wire serial PROM. Accepts one command at a
// time, shifts the frame out, captures read data, polls ready after
// programming, optionally appends a lock frame, then answers.
// Assumes: prom_do is synchronous to clk; SK_HALF >= 2.
module uwire_prom_host import uw_pkg::*; #(
    parameter int WORD_W        = 16,
    parameter int SK_HALF       = 2,
    parameter int CLK_PERIOD_NS = 20,
    parameter int CS_GAP_NS     = 250,
    parameter int POLL_LIMIT    = 4000,
    parameter bit AUTO_LOCK     = 1'b0,
    localparam int ADDR_W       = (WORD_W == 16) ? 6 : 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [2:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [WORD_W-1:0] req_data,
    output logic              rsp_valid,
    output logic [WORD_W-1:0] rsp_data,
    output logic              rsp_err,
    output logic              prom_cs,
    output logic              prom_sk,
    output logic              prom_di,
    input  logic              prom_do
);
    localparam int FW      = 3 + ADDR_W + WORD_W;
    localparam int CW      = $clog2(FW + 1);
    localparam int GAP_CYC = (CS_GAP_NS + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
    localparam int GAP_LIM = (GAP_CYC < 1) ? 1 : GAP_CYC;
    localparam logic [FW-1:0] LOCK_FRAME = {3'b100, {(FW-3){1'b0}}};

    uw_state_e         state_q;
    logic [FW-1:0]     frame_q;
    logic [CW-1:0]     left_q;
    logic [WORD_W-1:0] cap_q;
    logic              poll_pend_q, lock_pend_q, poll_first_q;
    logic              err_q, rsp_q, cs_q, sk_q;
    logic [FW-1:0]     new_frame;
    logic [CW-1:0]     new_nbits;
    logic              shifting, tick, gap_done, tmo_done;
    uw_op_e            op_in;

    assign op_in     = uw_op_e'(req_op);
    assign shifting  = (state_q == ST_SHIFT_LO) || (state_q == ST_SHIFT_HI);
    assign req_ready = (state_q == ST_IDLE);
    assign rsp_valid = rsp_q;
    assign rsp_data  = cap_q;
    assign rsp_err   = err_q;
    assign prom_cs   = cs_q;
    assign prom_sk   = sk_q;
    assign prom_di   = frame_q[FW-1];

    uw_frame #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_frame (
        .op(op_in), .addr(req_addr), .data(req_data),
        .frame(new_frame), .nbits(new_nbits)
    );

    uw_count #(.LIMIT(SK_HALF)) u_phase (
        .clk(clk), .rst_n(rst_n), .clr(!shifting), .en(shifting), .done(tick)
    );

    uw_count #(.LIMIT(GAP_LIM)) u_gap (
        .clk(clk), .rst_n(rst_n), .clr(state_q != ST_GAP),
        .en(state_q == ST_GAP), .done(gap_done)
    );

    uw_count #(.LIMIT(POLL_LIMIT)) u_tmo (
        .clk(clk), .rst_n(rst_n), .clr(state_q != ST_POLL),
        .en(state_q == ST_POLL), .done(tmo_done)
    );

    // Sequence frames, spacing, polling and the response strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q      <= ST_IDLE;
            frame_q      <= '0;
            left_q       <= '0;
            cap_q        <= '0;
            poll_pend_q  <= 1'b0;
            lock_pend_q  <= 1'b0;
            poll_first_q <= 1'b0;
            err_q        <= 1'b0;
            rsp_q        <= 1'b0;
            cs_q         <= 1'b0;
            sk_q         <= 1'b0;
        end else begin
            rsp_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: if (req_valid) begin
                    frame_q     <= new_frame;
                    left_q      <= new_nbits;
                    poll_pend_q <= uw_is_prog(op_in);
                    lock_pend_q <= AUTO_LOCK && uw_is_prog(op_in);
                    err_q       <= 1'b0;
                    cs_q        <= 1'b1;
                    state_q     <= ST_SHIFT_LO;
                end
                ST_SHIFT_LO: if (tick) begin
                    sk_q    <= 1'b1;
                    state_q <= ST_SHIFT_HI;
                end
                ST_SHIFT_HI: if (tick) begin
                    sk_q    <= 1'b0;
                    cap_q   <= {cap_q[WORD_W-2:0], prom_do};
                    frame_q <= frame_q << 1;
                    left_q  <= left_q - 1'b1;
                    if (left_q == CW'(1)) begin
                        cs_q    <= 1'b0;
                        state_q <= ST_GAP;
                    end else begin
                        state_q <= ST_SHIFT_LO;
                    end
                end
                ST_GAP: if (gap_done) begin
                    if (poll_pend_q) begin
                        poll_pend_q  <= 1'b0;
                        poll_first_q <= 1'b1;
                        cs_q         <= 1'b1;
                        state_q      <= ST_POLL;
                    end else if (lock_pend_q) begin
                        lock_pend_q <= 1'b0;
                        frame_q     <= LOCK_FRAME;
                        left_q      <= CW'(3 + ADDR_W);
                        cs_q        <= 1'b1;
                        state_q     <= ST_SHIFT_LO;
                    end else begin
                        rsp_q   <= 1'b1;
                        state_q <= ST_IDLE;
                    end
                end
                ST_POLL: begin
                    poll_first_q <= 1'b0;
                    if (!poll_first_q && prom_do) begin
                        cs_q    <= 1'b0;
                        state_q <= ST_GAP;
                    end else if (tmo_done) begin
                        err_q   <= 1'b1;
                        cs_q    <= 1'b0;
                        state_q <= ST_GAP;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // ---------------- assertions ----------------
    localparam int GCW = $clog2(GAP_LIM + 1);
    logic [GCW-1:0] low_cnt_q;

    // Count chip-select low cycles, saturating at the required spacing.
    always_ff @(posedge clk) begin
        if (!rst_n)                       low_cnt_q <= GCW'(GAP_LIM);
        else if (cs_q)                    low_cnt_q <= '0;
        else if (low_cnt_q < GCW'(GAP_LIM)) low_cnt_q <= low_cnt_q + 1'b1;
    end

    a_r6_cs_low_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(prom_cs) |-> (low_cnt_q >= GCW'(GAP_LIM)));

    a_r2_cs_rise_clk_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(prom_cs) |-> !prom_sk);

    a_r11_clk_only_selected: assert property (@(posedge clk) disable iff (!rst_n)
        prom_sk |-> prom_cs);

    a_r4_di_stable_clk_high: assert property (@(posedge clk) disable iff (!rst_n)
        (prom_sk && $past(prom_sk)) |-> $stable(prom_di));

    a_r10_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        prom_cs |-> !req_ready);

    a_r10_rsp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    a_r7_poll_clock_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_POLL) |-> (!prom_sk && prom_cs));

endmodule

// File: tb/test_uwire_prom_host.sv
// Scoreboard bench: a device model answers the serial lines, the
// driver queues expected responses, a monitor compares them.
module test_uwire_prom_host;
    localparam int WORD_W = 16;
    localparam int ADDR_W = 6;
    localparam int GAP_CYC = 13;
    localparam int BUSY_CYC = 80;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic req_ready;
    logic [2:0] req_op = '0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [WORD_W-1:0] req_data = '0;
    logic rsp_valid;
    logic [WORD_W-1:0] rsp_data;
    logic rsp_err;
    logic prom_cs, prom_sk, prom_di;
    logic prom_do = 1'b0;

    int n_cmp = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    uwire_prom_host #(.WORD_W(WORD_W), .SK_HALF(2), .CLK_PERIOD_NS(20),
        .CS_GAP_NS(250), .POLL_LIMIT(300), .AUTO_LOCK(1'b1)) i_uwire_prom_host (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_addr(req_addr), .req_data(req_data),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_err(rsp_err),
        .prom_cs(prom_cs), .prom_sk(prom_sk), .prom_di(prom_di), .prom_do(prom_do));

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // ---------------- device model (acts at negedge) ----------------
    logic [WORD_W-1:0] mem [64];
    int  m_busy = 0;
    bit  m_stuck = 1'b0;
    bit  m_wen = 1'b0;
    bit  m_prev_cs = 1'b0, m_prev_sk = 1'b0, m_prev_di = 1'b0;
    bit  m_started = 1'b0, m_rd = 1'b0, m_moved = 1'b0;
    int  m_cnt = 0, m_low = 1000;
    logic [31:0] m_sr = '0;
    logic [WORD_W-1:0] m_rdsr = '0;

    function automatic logic [WORD_W-1:0] init_word(input int i);
        return 16'h1000 + WORD_W'(i * 7);
    endfunction

    initial for (int i = 0; i < 64; i++) mem[i] = init_word(i);

    function automatic int frame_len(input logic [1:0] opc, input logic [1:0] ext);
        if (opc == 2'b10 || opc == 2'b01) return 24;
        if (opc == 2'b00 && ext == 2'b01) return 24;
        return 8;
    endfunction

    always @(negedge clk) begin
        if (rst_n) begin
            if (m_busy > 0) m_busy--;
            if (prom_sk && !prom_cs) check(0, "R11 clock while deselected", 1, 0);
            if (prom_sk && m_prev_sk && prom_di != m_prev_di) m_moved = 1'b1;
            if (prom_cs && !m_prev_cs) begin
                check(!prom_sk, "R2 clock low at select", prom_sk, 0);
                check(m_low >= GAP_CYC, "R6 chip-select spacing", m_low, GAP_CYC);
                m_started = 1'b0; m_cnt = 0; m_rd = 1'b0;
            end
            if (!prom_cs) m_low++; else m_low = 0;
            if (!prom_cs && m_prev_cs && m_started) begin
                check(m_cnt == frame_len(m_sr[m_cnt-1 -: 2], m_sr[m_cnt-3 -: 2]),
                      "R3 pulse count", m_cnt, frame_len(m_sr[m_cnt-1 -: 2], m_sr[m_cnt-3 -: 2]));
                if (m_wen && m_cnt == 8 && m_sr[7:6] == 2'b11) begin
                    mem[m_sr[5:0]] = '1; m_busy = BUSY_CYC;
                end else if (m_wen && m_cnt == 8 && m_sr[7:4] == 4'b0010) begin
                    for (int i = 0; i < 64; i++) mem[i] = '1;
                    m_busy = BUSY_CYC;
                end else if (m_wen && m_cnt == 24 && m_sr[23:22] == 2'b01) begin
                    mem[m_sr[21:16]] = m_sr[15:0]; m_busy = BUSY_CYC;
                end else if (m_wen && m_cnt == 24 && m_sr[23:20] == 4'b0001) begin
                    for (int i = 0; i < 64; i++) mem[i] = m_sr[15:0];
                    m_busy = BUSY_CYC;
                end
                m_started = 1'b0; m_rd = 1'b0;
            end
            if (prom_cs && prom_sk && !m_prev_sk) begin
                if (!m_started) begin
                    check(prom_di, "R2 start bit", prom_di, 1);
                    m_started = 1'b1; m_cnt = 0;
                end else begin
                    m_cnt++;
                    m_sr = {m_sr[30:0], prom_di};
                    if (m_cnt == 8) begin
                        if (m_sr[7:6] == 2'b10) begin
                            m_rd = 1'b1; m_rdsr = mem[m_sr[5:0]]; prom_do <= 1'b0;
                        end
                        if (m_sr[7:4] == 4'b0011) m_wen = 1'b1;
                        if (m_sr[7:4] == 4'b0000) m_wen = 1'b0;
                    end else if (m_rd) begin
                        prom_do <= m_rdsr[WORD_W-1];
                        m_rdsr = m_rdsr << 1;
                    end
                end
            end
            if (!prom_sk && m_prev_sk) begin
                check(!m_moved, "R4 data stable while clock high", m_moved, 0);
                m_moved = 1'b0;
            end
            if (prom_cs && !m_started) prom_do <= !(m_busy > 0 || m_stuck);
            else if (!prom_cs) prom_do <= 1'b0;
            m_prev_cs = prom_cs; m_prev_sk = prom_sk; m_prev_di = prom_di;
        end
    end

    // ---------------- scoreboard ----------------
    typedef struct {
        bit                chk_data;
        logic [WORD_W-1:0] data;
        bit                err;
        bit                prog;
        string             tag;
    } exp_t;
    exp_t sb_q [$];

    logic [WORD_W-1:0] ref_mem [64];
    bit ref_wen = 1'b0;
    initial for (int i = 0; i < 64; i++) ref_mem[i] = init_word(i);

    // Monitor: compare every response with the oldest expectation.
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (sb_q.size() == 0) begin
                check(0, "R10 unexpected response", 1, 0);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                if (e.chk_data)
                    check(rsp_data == e.data, e.tag, rsp_data, e.data);
                check(rsp_err == e.err, e.err ? "R8 timeout flag" : "R8 no error", rsp_err, e.err);
                if (e.prog && !e.err)
                    check(m_busy == 0, "R7 answered only after ready", m_busy, 0);
            end
        end
    end

    task automatic do_req(input logic [2:0] op, input logic [ADDR_W-1:0] a,
                          input logic [WORD_W-1:0] d, input bit exp_err, input string tag);
        exp_t e;
        bit prog;
        prog = (op == 3'd1 || op == 3'd2 || op == 3'd5 || op == 3'd6);
        e.chk_data = (op == 3'd0);
        e.data = ref_mem[a];
        e.err = exp_err;
        e.prog = prog;
        e.tag = tag;
        if (ref_wen) begin
            case (op)
                3'd1: ref_mem[a] = d;
                3'd2: ref_mem[a] = '1;
                3'd5: for (int i = 0; i < 64; i++) ref_mem[i] = '1;
                3'd6: for (int i = 0; i < 64; i++) ref_mem[i] = d;
                default: ;
            endcase
        end
        if (op == 3'd3) ref_wen = 1'b1;
        if (op == 3'd4 || op == 3'd7) ref_wen = 1'b0;
        if (prog) ref_wen = 1'b0;
        while (!req_ready) @(negedge clk);
        sb_q.push_back(e);
        req_op = op; req_addr = a; req_data = d; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check(!req_ready, "R10 ready low while serving", req_ready, 0);
        while (sb_q.size() != 0) @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!prom_cs, "R1 cs low after reset", prom_cs, 0);
        check(!prom_sk, "R1 clock low after reset", prom_sk, 0);
        check(req_ready, "R1 ready after reset", req_ready, 1);
        check(!rsp_valid, "R1 no response after reset", rsp_valid, 0);

        do_req(3'd0, 6'd3, '0, 0, "R5 read initial word");
        do_req(3'd1, 6'd3, 16'h1111, 0, "R7 write while locked");
        do_req(3'd0, 6'd3, '0, 0, "R5 locked write left word");
        do_req(3'd3, '0, '0, 0, "R3 unlock");
        do_req(3'd1, 6'd3, 16'h1234, 0, "R7 write");
        do_req(3'd0, 6'd3, '0, 0, "R5 read back write");
        do_req(3'd1, 6'd3, 16'hFFFF, 0, "R9 write after auto lock");
        do_req(3'd0, 6'd3, '0, 0, "R9 auto lock kept word");
        do_req(3'd3, '0, '0, 0, "R3 unlock");
        do_req(3'd1, 6'd63, 16'h8001, 0, "R3 write top address");
        do_req(3'd0, 6'd63, '0, 0, "R5 read top address");
        do_req(3'd3, '0, '0, 0, "R3 unlock");
        do_req(3'd2, 6'd3, '0, 0, "R7 erase");
        do_req(3'd0, 6'd3, '0, 0, "R5 read erased");
        do_req(3'd3, '0, '0, 0, "R3 unlock");
        do_req(3'd4, '0, '0, 0, "R3 lock");
        do_req(3'd1, 6'd10, 16'h0000, 0, "R3 write after lock");
        do_req(3'd0, 6'd10, '0, 0, "R3 lock kept word");
        do_req(3'd3, '0, '0, 0, "R3 unlock");
        do_req(3'd6, '0, 16'h5A5A, 0, "R7 write all");
        do_req(3'd0, 6'd0, '0, 0, "R5 write-all word 0");
        do_req(3'd0, 6'd40, '0, 0, "R5 write-all word 40");
        do_req(3'd3, '0, '0, 0, "R3 unlock");
        do_req(3'd5, '0, '0, 0, "R7 erase all");
        do_req(3'd0, 6'd17, '0, 0, "R5 erase-all word 17");
        m_stuck = 1'b1;
        do_req(3'd3, '0, '0, 0, "R3 unlock");
        do_req(3'd1, 6'd2, 16'h2222, 1, "R8 stuck busy");
        m_stuck = 1'b0;
        do_req(3'd0, 6'd2, '0, 0, "R5 read after timeout");
        repeat (20) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule